// File: doc/BRIEF.md
# Flash Word Write Sequencer

This block programs a run of 32-bit image words into a target's on-chip flash by driving that target's flash controller registers over a generic single-word memory-access port. A job is launched with a start pulse that carries the first target byte address, the number of words and three mode flags. The block then loads the controller's address register, writes each word taken from an input stream into the controller's write-data register, and paces the writes either by reading the controller status register until its ready flag returns or by waiting a fixed number of clock cycles.

Targets whose address register steps by 4 after every data write get one address load at the start of the job and one more at each flash page boundary. Targets flagged as lacking that step get an address load before every word. In double-write mode two data words go out back to back before the block waits. An odd final word is then followed by an all-ones pad word. When polling, a ready flag that stays clear for a configured number of status reads ends the job with an error.

The image stream follows valid/ready rules. The producer holds `img_valid` and `img_data` steady until a cycle in which `img_ready` is also high; that cycle transfers one word. The block raises `img_ready` only while it is waiting for the next word to write and never while a bus request is pending, so a slow producer just stretches the job. The memory port is a request/acknowledge pair: every request field stays constant from the raising of `mem_req` until the cycle in which `mem_ack` is high, and that cycle completes the access. A start pulse is taken only while the block is idle.

Top module: `flash_word_writer`

## Requirements
- R1: Out of reset `done`, `err`, `img_ready` and `mem_req` are low.
- R2: The first access of a job with a nonzero count is a write of the start address to the address register (`CTRL_BASE + ADDR_OFS`).
- R3: With `no_autoinc` low the address register is written once at the start and again only before a word whose target address is a multiple of `PAGE_BYTES`.
- R4: With `no_autoinc` high the address register is written before every image word, with that word's target address.
- R5: Image words are written to the data register (`CTRL_BASE + WDATA_OFS`) in stream order, one word per target address step of 4, so word i lands at start address + 4*i.
- R6: With `skip_poll` low, after each write unit the status register (`CTRL_BASE + STATUS_OFS`) is read until a read returns a value with a bit of `RDY_MASK` set (bit 3 by default), and no further data word is written before that read.
- R7: With `skip_poll` high no status read is issued, and at least `CLK_MHZ*DELAY_US` clock cycles pass between the completion of a write unit and the next data write.
- R8: With double-write in effect a write unit is two data writes with no status read or delay between them; an odd count ends with a pad word of 0xFFFFFFFF after the last image word.
- R9: `dbl_write` has no effect when `no_autoinc` is high: every unit is a single word and no pad is written.
- R10: When polling, `TMO_READS` consecutive status reads without ready end the job with `done` and `err` both high and no further bus access; `err` stays high until the next start.
- R11: A job with a word count of zero raises `done` with `err` low and issues no bus access and takes no stream word.
- R12: Exactly as many stream words as the word count are taken per job, and `img_ready` is never high while `mem_req` is high.
- R13: Once `mem_req` is raised, `mem_we`, `mem_addr` and `mem_wdata` hold their values until the cycle with `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job launch, taken while idle |
| start_addr | input | 32 | Target byte address of the first word |
| word_cnt | input | CNT_W | Number of image words in the job |
| no_autoinc | input | 1 | Target lacks address step; reload before every word |
| dbl_write | input | 1 | Write two words per unit |
| skip_poll | input | 1 | Use fixed delay instead of status reads |
| img_valid | input | 1 | Stream word available |
| img_ready | output | 1 | Block accepts a stream word this cycle |
| img_data | input | 32 | Stream word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Register address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle end-of-job pulse |
| err | output | 1 | Job ended on status timeout |

## Verification
A stale internal word address shows up as image words landing at the wrong target location or as a missing or extra address-register write, visible at the end of the same job. A pacing fault shows up as a data write at the bus port before a ready status read or before the delay has run out; a model of the target flags it in the cycle of that write. A miscounted remainder shows up as one stream word too many or too few, or a pad word appearing or missing, by the time `done` pulses.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LDADDR,
    S_FETCH,
    S_WR,
    S_DLY,
    S_POLL,
    S_DONE
  } fws_state_e;

  localparam logic [31:0] PAD_WORD = 32'hFFFF_FFFF;
endpackage

// File: rtl/fws_cursor.sv
module fws_cursor #(
  parameter int CNT_W      = 16,
  parameter int PAGE_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_addr,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             step,
  output logic [31:0]      addr,
  output logic             rem_zero,
  output logic             last_word,
  output logic             at_page
);
  localparam int PG_LSB = $clog2(PAGE_BYTES);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      rem_q <= '0;
    end else if (load) begin
      addr  <= load_addr;
      rem_q <= load_cnt;
    end else if (step) begin
      addr  <= addr + 32'd4;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign rem_zero  = (rem_q == '0);
  assign last_word = (rem_q == CNT_W'(1));
  assign at_page   = (addr[PG_LSB-1:0] == '0);

  // R12
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !rem_zero);
endmodule

// File: rtl/fws_pacer.sv
module fws_pacer #(
  parameter int DLY_CYC   = 1375,
  parameter int TMO_READS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dly_go,
  input  logic poll_clr,
  input  logic poll_miss,
  output logic dly_end,
  output logic miss_last
);
  localparam int DW = $clog2(DLY_CYC + 1);
  localparam int TW = $clog2(TMO_READS + 1);

  logic [DW-1:0] dly_q;
  logic [TW-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (dly_go) begin
      dly_q <= DW'(DLY_CYC - 1);
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || poll_clr) begin
      miss_q <= '0;
    end else if (poll_miss) begin
      miss_q <= miss_q + 1'b1;
    end
  end

  assign dly_end   = (dly_q == '0);
  assign miss_last = (miss_q == TW'(TMO_READS - 1));

  // R10
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_miss |-> !miss_last);
endmodule

// File: rtl/flash_word_writer.sv
module flash_word_writer #(
  parameter int          CNT_W      = 16,
  parameter int          PAGE_BYTES = 2048,
  parameter int          CLK_MHZ    = 125,
  parameter int          DELAY_US   = 11,
  parameter int          TMO_READS  = 64,
  parameter logic [31:0] CTRL_BASE  = 32'h400C_0000,
  parameter logic [31:0] ADDR_OFS   = 32'h0000_0010,
  parameter logic [31:0] WDATA_OFS  = 32'h0000_0018,
  parameter logic [31:0] STATUS_OFS = 32'h0000_001C,
  parameter logic [31:0] RDY_MASK   = 32'h0000_0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      start_addr,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic             no_autoinc,
  input  logic             dbl_write,
  input  logic             skip_poll,
  input  logic             img_valid,
  output logic             img_ready,
  input  logic [31:0]      img_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic             err
);
  import fws_pkg::*;

  localparam int          DLY_CYC  = (CLK_MHZ * DELAY_US < 1) ? 1 : CLK_MHZ * DELAY_US;
  localparam logic [31:0] A_ADDR   = CTRL_BASE + ADDR_OFS;
  localparam logic [31:0] A_WDATA  = CTRL_BASE + WDATA_OFS;
  localparam logic [31:0] A_STATUS = CTRL_BASE + STATUS_OFS;

  fws_state_e  state_q, state_d;
  logic [31:0] wbuf_q;
  logic        second_q, pad_q;
  logic        na_q, dbl_q, skp_q;

  logic        cur_load, cur_step;
  logic [31:0] cur_addr;
  logic        rem_zero, last_word, at_page;
  logic        dly_go, poll_clr, poll_miss, dly_end, miss_last;
  logic        rdy_seen;
  logic        wr_ack;
  fws_state_e  after_wait;

  fws_cursor #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cur_load),
    .load_addr (start_addr),
    .load_cnt  (word_cnt),
    .step      (cur_step),
    .addr      (cur_addr),
    .rem_zero  (rem_zero),
    .last_word (last_word),
    .at_page   (at_page)
  );

  fws_pacer #(.DLY_CYC(DLY_CYC), .TMO_READS(TMO_READS)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .dly_go    (dly_go),
    .poll_clr  (poll_clr),
    .poll_miss (poll_miss),
    .dly_end   (dly_end),
    .miss_last (miss_last)
  );

  assign rdy_seen = ((mem_rdata & RDY_MASK) != '0);
  assign wr_ack   = (state_q == S_WR) && mem_ack;

  // next step once a write unit has been paced out
  always_comb begin
    if (rem_zero)                after_wait = S_DONE;
    else if (na_q || at_page)    after_wait = S_LDADDR;
    else                         after_wait = S_FETCH;
  end

  always_comb begin
    state_d   = state_q;
    cur_load  = 1'b0;
    cur_step  = 1'b0;
    dly_go    = 1'b0;
    poll_clr  = 1'b0;
    poll_miss = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        cur_load = 1'b1;
        state_d  = (word_cnt == '0) ? S_DONE : S_LDADDR;
      end
      S_LDADDR: if (mem_ack) state_d = S_FETCH;
      S_FETCH:  if (img_valid) state_d = S_WR;
      S_WR: if (mem_ack) begin
        cur_step = !pad_q;
        if (dbl_q && !second_q) begin
          state_d = last_word ? S_WR : S_FETCH;
        end else if (skp_q) begin
          dly_go  = 1'b1;
          state_d = S_DLY;
        end else begin
          poll_clr = 1'b1;
          state_d  = S_POLL;
        end
      end
      S_DLY: if (dly_end) state_d = after_wait;
      S_POLL: if (mem_ack) begin
        if (rdy_seen)       state_d = after_wait;
        else if (miss_last) state_d = S_DONE;
        else                poll_miss = 1'b1;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wbuf_q   <= '0;
      second_q <= 1'b0;
      pad_q    <= 1'b0;
      na_q     <= 1'b0;
      dbl_q    <= 1'b0;
      skp_q    <= 1'b0;
      err      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start) begin
        na_q     <= no_autoinc;
        dbl_q    <= dbl_write && !no_autoinc;
        skp_q    <= skip_poll;
        second_q <= 1'b0;
        pad_q    <= 1'b0;
        err      <= 1'b0;
      end
      if (state_q == S_FETCH && img_valid) wbuf_q <= img_data;
      if (wr_ack) begin
        if (dbl_q && !second_q) begin
          second_q <= 1'b1;
          if (last_word) begin
            wbuf_q <= PAD_WORD;
            pad_q  <= 1'b1;
          end
        end else begin
          second_q <= 1'b0;
          pad_q    <= 1'b0;
        end
      end
      if (state_q == S_POLL && mem_ack && !rdy_seen && miss_last) err <= 1'b1;
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = A_STATUS;
    mem_wdata = '0;
    unique case (state_q)
      S_LDADDR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = A_ADDR;
        mem_wdata = cur_addr;
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = A_WDATA;
        mem_wdata = wbuf_q;
      end
      S_POLL:  mem_req = 1'b1;
      default: mem_req = 1'b0;
    endcase
  end

  assign img_ready = (state_q == S_FETCH);
  assign done      = (state_q == S_DONE);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R12
  ready_vs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_ready |-> !mem_req);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |=> !mem_req && !img_ready);

  // R7
  skip_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !skp_q);

  // R8
  pair_no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && dbl_q && !second_q |=> !(mem_req && !mem_we));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_req);
endmodule

// File: tb/sim_flash_word_writer.sv
module sim_flash_word_writer;
  localparam int          CNT_W = 8;
  localparam int          PB    = 16;
  localparam int          CMHZ  = 4;
  localparam int          DUS   = 2;
  localparam int          DLY   = CMHZ * DUS;
  localparam int          TMO   = 6;
  localparam logic [31:0] BASE  = 32'h400C_0000;
  localparam logic [31:0] A_ADR = BASE + 32'h10;
  localparam logic [31:0] A_WD  = BASE + 32'h18;
  localparam logic [31:0] A_ST  = BASE + 32'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [CNT_W-1:0] word_cnt = '0;
  logic no_autoinc = 1'b0, dbl_write = 1'b0, skip_poll = 1'b0;
  logic img_valid, img_ready;
  logic [31:0] img_data;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic done, err;

  always #4 clk = ~clk;

  flash_word_writer #(
    .CNT_W(CNT_W), .PAGE_BYTES(PB), .CLK_MHZ(CMHZ), .DELAY_US(DUS), .TMO_READS(TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .word_cnt(word_cnt),
    .no_autoinc(no_autoinc), .dbl_write(dbl_write), .skip_poll(skip_poll),
    .img_valid(img_valid), .img_ready(img_ready), .img_data(img_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .err(err)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  logic [31:0] fmem [0:63];
  int jobno = 0;
  bit j_na, j_dbl, j_skip, stream_on;
  int busy_k;
  int nops, naddr, ndata, nstat, viol, took;
  logic first_we;
  logic [31:0] first_addr, first_wd, mcur;
  bit need_ready, seen_ready, pair_open;
  int last_unit, busy_left, sidx, gap;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (job %0d)", req, act, exp, jobno);
    end
  endtask

  function automatic logic [31:0] word_of(input int j, input int i);
    return 32'hC000_0000 | (32'(j) << 8) | 32'(i);
  endfunction

  // target controller and flash model plus stream producer
  initial begin
    logic s_bus, s_req, s_img, s_we;
    logic [31:0] s_addr, s_wd, s_rd;
    mem_ack = 1'b0; mem_rdata = '0; img_valid = 1'b0; img_data = '0;
    forever begin
      @(negedge clk);
      s_bus = mem_req & mem_ack; s_req = mem_req; s_we = mem_we;
      s_addr = mem_addr; s_wd = mem_wdata; s_rd = mem_rdata;
      s_img = img_valid & img_ready;
      @(posedge clk);
      cyc++;
      #1;
      if (s_bus) begin
        nops++;
        if (nops == 1) begin first_we = s_we; first_addr = s_addr; first_wd = s_wd; end
        if (s_we && s_addr == A_ADR) begin
          naddr++; mcur = s_wd;
        end else if (s_we && s_addr == A_WD) begin
          if (!pair_open) begin
            if (need_ready) begin
              if (j_skip) begin if (cyc - last_unit < DLY) viol++; end
              else if (!seen_ready) viol++;
            end
            need_ready = 1'b0;
          end
          fmem[mcur[7:2]] = s_wd;
          ndata++;
          if (!j_na) mcur = mcur + 32'd4;
          if ((j_dbl && !j_na) && !pair_open) pair_open = 1'b1;
          else begin
            pair_open = 1'b0; need_ready = 1'b1; seen_ready = 1'b0;
            last_unit = cyc; busy_left = busy_k;
          end
        end else if (!s_we && s_addr == A_ST) begin
          nstat++;
          if (pair_open) viol++;
          if (s_rd[3]) seen_ready = 1'b1;
          else if (busy_left > 0) busy_left--;
        end else viol++;
        mem_ack = 1'b0;
      end else if (s_req) begin
        mem_ack = 1'b1;
        mem_rdata = (busy_left == 0) ? 32'h0000_0008 : 32'h0000_0000;
      end
      if (s_img) begin
        took++;
        sidx++;
        img_data = word_of(jobno, sidx);
        gap = sidx % 3;
        if (gap > 0) img_valid = 1'b0;
      end else if (!img_valid) begin
        if (gap > 0) gap--;
        if (gap == 0 && stream_on) img_valid = 1'b1;
      end
      if (!stream_on) img_valid = 1'b0;
    end
  end

  function automatic int exp_addr(input int st, input int cnt, input bit na);
    int n;
    if (cnt == 0) return 0;
    if (na) return cnt;
    n = 1;
    for (int i = 1; i < cnt; i++) if (((st + 4 * i) % PB) == 0) n++;
    return n;
  endfunction

  task automatic run_job(input int st, input int cnt, input bit na, input bit dbl,
                         input bit skp, input int k, output bit got_err, output bit hung);
    int guard;
    @(negedge clk);
    jobno++;
    for (int i = 0; i < 64; i++) fmem[i] = 32'h5A00_0000 | 32'(i);
    j_na = na; j_dbl = dbl; j_skip = skp; busy_k = k;
    nops = 0; naddr = 0; ndata = 0; nstat = 0; viol = 0; took = 0;
    need_ready = 1'b0; seen_ready = 1'b0; pair_open = 1'b0; busy_left = 0;
    first_we = 1'b0; first_addr = '0; first_wd = '0;
    sidx = 0; gap = 0; img_data = word_of(jobno, 0); stream_on = 1'b1;
    start_addr = 32'(st); word_cnt = CNT_W'(cnt);
    no_autoinc = na; dbl_write = dbl; skip_poll = skp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin @(negedge clk); guard++; end
    hung = !done;
    got_err = err;
    stream_on = 1'b0;
    repeat (2) @(negedge clk);
    if (hung) chk(1'b0, "watchdog", 32'(guard), 32'd0);
  endtask

  initial begin
    bit e, h;
    bit de;
    int pad, base;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!done && !err && !img_ready && !mem_req, "R1",
        {28'd0, done, err, img_ready, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !err && !img_ready && !mem_req, "R1",
        {28'd0, done, err, img_ready, mem_req}, 32'd0);

    for (int na = 0; na < 2; na++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int skp = 0; skp < 2; skp++)
          for (int st = 0; st < PB; st += 4)
            for (int cnt = 0; cnt < 7; cnt++) begin
              de = (dbl == 1) && (na == 0);
              if (de && (st % 8 != 0)) continue;
              run_job(st, cnt, na[0], dbl[0], skp[0], jobno % 3, e, h);
              if (h) continue;
              pad = (de && (cnt % 2 == 1)) ? 1 : 0;
              base = st / 4;
              chk(!e, "R10", {31'd0, e}, 32'd0);
              if (cnt == 0) begin
                // R11 zero-length job
                chk(nops == 0 && took == 0, "R11", 32'(nops + took), 32'd0);
                continue;
              end
              // R2 first access loads the address register
              chk(first_we && first_addr == A_ADR && first_wd == 32'(st), "R2", first_wd, 32'(st));
              if (na == 1) chk(naddr == cnt, "R4", 32'(naddr), 32'(cnt));
              else         chk(naddr == exp_addr(st, cnt, 1'b0), "R3", 32'(naddr), 32'(exp_addr(st, cnt, 1'b0)));
              for (int i = 0; i < cnt; i++)
                chk(fmem[base + i] == word_of(jobno, i), "R5", fmem[base + i], word_of(jobno, i));
              if (pad == 1) chk(fmem[base + cnt] == 32'hFFFF_FFFF, "R8", fmem[base + cnt], 32'hFFFF_FFFF);
              else chk(fmem[base + cnt] == (32'h5A00_0000 | 32'(base + cnt)),
                       (dbl == 1 && na == 1) ? "R9" : "R5",
                       fmem[base + cnt], 32'h5A00_0000 | 32'(base + cnt));
              chk(ndata == cnt + pad, (dbl == 1 && na == 1) ? "R9" : "R8", 32'(ndata), 32'(cnt + pad));
              chk(took == cnt, "R12", 32'(took), 32'(cnt));
              if (skp == 1) begin
                chk(nstat == 0, "R7", 32'(nstat), 32'd0);
                chk(viol == 0, "R7", 32'(viol), 32'd0);
              end else begin
                chk(viol == 0, de ? "R8" : "R6", 32'(viol), 32'd0);
                chk(nstat >= (cnt + pad) / (de ? 2 : 1), "R6", 32'(nstat), 32'((cnt + pad) / (de ? 2 : 1)));
              end
            end

    // R10 status never ready: timeout
    run_job(0, 3, 1'b0, 1'b0, 1'b0, 1000, e, h);
    chk(e, "R10", {31'd0, e}, 32'd1);
    chk(nstat == TMO, "R10", 32'(nstat), 32'(TMO));
    chk(ndata == 1, "R10", 32'(ndata), 32'd1);
    chk(err, "R10", {31'd0, err}, 32'd1);
    // next job clears the error
    run_job(8, 2, 1'b0, 1'b0, 1'b0, 1, e, h);
    chk(!e, "R10", {31'd0, e}, 32'd0);
    chk(fmem[3] == word_of(jobno, 1), "R5", fmem[3], word_of(jobno, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule